// File: doc/BRIEF.md
# Two-Half Masked Interrupt Collector

This block gathers up to 64 level-sensitive interrupt sources into one cause vector. It combines that vector with a per-source enable mask to drive a single registered interrupt line towards a CPU. Software sees the cause and the mask as pairs of 32-bit words. The mask is programmed one word at a time. A cause bit mirrors its source level: software cannot clear it, and it drops only when the source drops. Some source positions are reserved and always read as zero. Among the others, positions 56 to 59 carry the four GPIO group summaries.

A "select" read folds the 64 causes into one 32-bit word, so an interrupt handler can find the active half with a single access. Bit 30 marks a returned word that is the upper half. Bit 31 marks the lower half returned while masked causes are also pending in the upper half.

Register access uses plain strobes. A write takes effect on the clock edge that samples it. A read request returns its data one cycle later with a one-cycle valid pulse. There is no back-pressure: the block accepts every request and the requester must always take the returned word. Register index (3 bits): 0 cause low, 1 cause high, 2 mask low, 3 mask high, 4 select. Bit k of a high word is source 32+k.

Top module: `irq_aggr`

## Requirements
- R1: Each cause bit equals its source level as sampled on the previous rising clock edge. After reset, every cause bit is 0.
- R2: Source positions 29, 30, 31, 35, 51 to 55 and 61 to 63 are reserved. They always read as 0 in the cause and never contribute to the interrupt line.
- R3: A write to index 2 loads mask bits 31:0, and a write to index 3 loads mask bits 63:32. Each write leaves the other half unchanged. Both halves read back at the same indices and are 0 after reset.
- R4: Index 0 reads cause bits 31:0 and index 1 reads cause bits 63:32. Writes to indices 0, 1 and 4 have no effect on any state.
- R5: The output `irq` is a register equal to the OR of (cause AND mask). It changes on the same edge that updates the cause or the mask and is 0 after reset.
- R6: A select read (index 4) with no masked cause pending returns cause bits 31:0 unchanged.
- R7: A select read with masked causes pending only in bits 63:32 returns cause bits 63:32 with bit 30 set.
- R8: A select read with masked causes pending in both halves returns cause bits 31:0 with bit 31 set.
- R9: A select read with masked causes pending only in bits 31:0 returns cause bits 31:0 unchanged, whatever unmasked causes exist in the upper half.
- R10: Each `rd_en` cycle produces exactly one `rd_valid` pulse on the next cycle, carrying the value at the time of the request. Indices 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt source levels |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rd_idx | input | 3 | Register index of the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Registered CPU interrupt line |

## Verification
The bench builds the block with its default half width of 32 and the default reserved-position mask, so that the flag bits 30 and 31 of the select word fall in reserved positions of each half. This lets all four select outcomes be told apart from ordinary cause bits. Sources are placed on both sides of the half boundary (positions 0, 31, 32, 63) and on reserved positions. Together with independent writes to each mask half, this reaches every select branch and the case where unmasked upper causes must not disturb the low-only result.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  typedef enum logic [2:0] {
    IDX_CAUSE_LO = 3'd0,
    IDX_CAUSE_HI = 3'd1,
    IDX_MASK_LO  = 3'd2,
    IDX_MASK_HI  = 3'd3,
    IDX_SELECT   = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/irq_cause_capture.sv
module irq_cause_capture #(
  parameter int NSRC = 64,
  parameter logic [NSRC-1:0] RSVD_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] cause_nxt_o,
  output logic [NSRC-1:0] cause_o
);
  // reserved positions are forced low before they are stored
  assign cause_nxt_o = src_i & ~RSVD_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_o <= '0;
    else        cause_o <= cause_nxt_o;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int HALF_W = 32,
  localparam int NSRC = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_half_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [NSRC-1:0]   mask_nxt_o,
  output logic [NSRC-1:0]   mask_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic sel;
    assign sel = wr_en_i && (wr_half_i == h[0]);
    assign mask_nxt_o[h*HALF_W +: HALF_W] = sel ? wr_data_i : mask_o[h*HALF_W +: HALF_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_o[h*HALF_W +: HALF_W] <= '0;
      else        mask_o[h*HALF_W +: HALF_W] <= mask_nxt_o[h*HALF_W +: HALF_W];
    end
  end
endmodule

// File: rtl/irq_sel_fold.sv
module irq_sel_fold #(
  parameter int HALF_W = 32,
  localparam int NSRC = 2 * HALF_W
) (
  input  logic [NSRC-1:0]   cause_i,
  input  logic [NSRC-1:0]   mask_i,
  output logic [HALF_W-1:0] word_o
);
  logic [HALF_W-1:0] pend_lo, pend_hi;
  logic              any_lo, any_hi;

  assign pend_lo = cause_i[HALF_W-1:0] & mask_i[HALF_W-1:0];
  assign pend_hi = cause_i[NSRC-1:HALF_W] & mask_i[NSRC-1:HALF_W];
  assign any_lo  = |pend_lo;
  assign any_hi  = |pend_hi;

  always_comb begin
    word_o = cause_i[HALF_W-1:0];
    if (any_hi && !any_lo) begin
      word_o = cause_i[NSRC-1:HALF_W];
      word_o[HALF_W-2] = 1'b1;
    end else if (any_hi) begin
      word_o[HALF_W-1] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr #(
  parameter int HALF_W = 32,
  parameter logic [2*HALF_W-1:0] RSVD_MASK = 64'hE0F8_0008_E000_0000,
  localparam int NSRC = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_idx,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_data,
  output logic              irq
);
  import irq_aggr_pkg::*;

  logic [NSRC-1:0]   cause, cause_nxt, mask, mask_nxt;
  logic [HALF_W-1:0] sel_word;
  logic              mask_wr;

  assign mask_wr = wr_en && (wr_idx == IDX_MASK_LO || wr_idx == IDX_MASK_HI);

  irq_cause_capture #(.NSRC(NSRC), .RSVD_MASK(RSVD_MASK)) u_cause (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .cause_nxt_o(cause_nxt), .cause_o(cause)
  );

  irq_mask_bank #(.HALF_W(HALF_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en_i(mask_wr),
    .wr_half_i(wr_idx == IDX_MASK_HI), .wr_data_i(wr_data),
    .mask_nxt_o(mask_nxt), .mask_o(mask)
  );

  irq_sel_fold #(.HALF_W(HALF_W)) u_fold (
    .cause_i(cause), .mask_i(mask), .word_o(sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(cause_nxt & mask_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_idx)
          IDX_CAUSE_LO: rd_data <= cause[HALF_W-1:0];
          IDX_CAUSE_HI: rd_data <= cause[NSRC-1:HALF_W];
          IDX_MASK_LO:  rd_data <= mask[HALF_W-1:0];
          IDX_MASK_HI:  rd_data <= mask[NSRC-1:HALF_W];
          IDX_SELECT:   rd_data <= sel_word;
          default:      rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter int HALF_W = 32,
  parameter logic [2*HALF_W-1:0] RSVD_MASK = '0,
  localparam int NSRC = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_i,
  input logic              wr_en,
  input logic [2:0]        wr_idx,
  input logic              rd_en,
  input logic [2:0]        rd_idx,
  input logic              rd_valid,
  input logic [HALF_W-1:0] rd_data,
  input logic              irq,
  input logic [NSRC-1:0]   cause,
  input logic [NSRC-1:0]   mask
);
  logic [HALF_W-1:0] plo, phi;
  assign plo = cause[HALF_W-1:0] & mask[HALF_W-1:0];
  assign phi = cause[NSRC-1:HALF_W] & mask[NSRC-1:HALF_W];

  AST_CAUSE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cause == ($past(src_i) & ~RSVD_MASK)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & RSVD_MASK) == '0); // R2
  AST_MASK_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd2) |=> $stable(mask[NSRC-1:HALF_W])); // R3
  AST_MASK_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd3) |=> $stable(mask[HALF_W-1:0])); // R3
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(cause & mask)); // R5
  AST_SEL_HIGH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 3'd4 && plo == '0 && phi != '0) |=> rd_data[HALF_W-2]); // R7
  AST_SEL_BOTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 3'd4 && plo != '0 && phi != '0) |=> rd_data[HALF_W-1]); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R10
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R10
endmodule

bind irq_aggr irq_aggr_chk #(.HALF_W(HALF_W), .RSVD_MASK(RSVD_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .wr_idx(wr_idx),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
  .irq(irq), .cause(cause), .mask(mask)
);

// File: tb/irq_aggr_test.sv
module irq_aggr_test;
  localparam logic [63:0] RSVD = 64'hE0F8_0008_E000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_src = '0;
  logic [63:0] m_mask = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_aggr uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [2:0] idx);
    logic [63:0] c, p;
    c = m_src & ~RSVD;
    p = c & m_mask;
    case (idx)
      3'd0: return c[31:0];
      3'd1: return c[63:32];
      3'd2: return m_mask[31:0];
      3'd3: return m_mask[63:32];
      3'd4: begin
        if (p[63:32] != 0 && p[31:0] == 0) return c[63:32] | 32'h4000_0000;
        if (p[63:32] != 0)                 return c[31:0] | 32'h8000_0000;
        return c[31:0];
      end
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issue a read and push its expected word to the scoreboard
  task automatic rd(input logic [2:0] idx, input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    rd_idx = idx;
    exp_q.push_back(model_read(idx));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    if (idx == 3'd2) m_mask[31:0] = d;
    if (idx == 3'd3) m_mask[63:32] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src_i = v; m_src = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input string tag);
    check(tag, {31'b0, irq}, {31'b0, |((m_src & ~RSVD) & m_mask)});
  endtask

  // monitor: pop and compare on every returned word
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 spurious rd_valid", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: R1, R3, R5
    rd(3'd0, "R1 reset cause lo");
    rd(3'd1, "R1 reset cause hi");
    rd(3'd2, "R3 reset mask lo");
    rd(3'd3, "R3 reset mask hi");
    chk_irq("R5 reset irq");

    // all sources high: reserved bits read zero (R2, R1)
    set_src('1);
    rd(3'd0, "R2 cause lo all-ones");
    rd(3'd1, "R2 cause hi all-ones");

    // writes to cause / select indices ignored (R4)
    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'h0000_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, "R4 cause lo after write");
    rd(3'd1, "R4 cause hi after write");
    rd(3'd2, "R4 mask lo after cause write");

    // independent mask halves (R3)
    wr(3'd2, 32'hA5A5_A5A5);
    wr(3'd3, 32'h5A5A_5A5A);
    wr(3'd2, 32'h0000_1234);
    rd(3'd3, "R3 mask hi kept");
    rd(3'd2, "R3 mask lo");
    wr(3'd3, 32'h0000_0000);
    rd(3'd2, "R3 mask lo kept");

    // unmapped indices (R10)
    rd(3'd5, "R10 index 5");
    rd(3'd7, "R10 index 7");

    // no masked pending (R6)
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    set_src(64'h8000_0001_0000_0005);
    rd(3'd4, "R6 select none pending");
    chk_irq("R5 irq masked off");

    // high only (R7)
    wr(3'd3, 32'h0000_0001);
    chk_irq("R5 irq high mask");
    rd(3'd4, "R7 select high only");
    set_src(64'h0000_0001_0000_0000);
    rd(3'd4, "R7 select high only, no low causes");

    // both halves (R8)
    wr(3'd2, 32'h0000_0001);
    set_src(64'h0000_0001_4000_0001);
    rd(3'd4, "R8 select both halves");
    // bit 63 region: source 60 masked in high half
    wr(3'd3, 32'h1000_0000);
    set_src(64'h1000_0000_0000_0001);
    rd(3'd4, "R8 select both with source 60");

    // low only, unmasked high causes present (R9)
    wr(3'd3, 32'h0);
    set_src(64'h1F07_FFF7_0000_0001);
    rd(3'd4, "R9 select low only");
    chk_irq("R5 irq low only");

    // reserved source with full mask never raises irq (R2)
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
    set_src(RSVD);
    chk_irq("R2 reserved sources no irq");
    rd(3'd4, "R2 select reserved only");

    // irq timing: changes on the edge that samples the source (R5)
    @(negedge clk);
    src_i = 64'h0000_0000_0000_0100; m_src = src_i;
    check("R5 irq before edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk_irq("R5 irq after one edge");
    set_src('0);
    chk_irq("R1 source drop clears");
    rd(3'd0, "R1 cause cleared by source");

    repeat (3) @(negedge clk);
    check("R10 all reads returned", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule